// File: doc/BRIEF.md
# Voltage-Frequency Working-Point Sequencer

This block steps a processor between a small set of operating points. Each point pairs a clock frequency code with a supply voltage code, and a higher index stands for a faster, higher-voltage point. Software writes a target index. The sequencer then drives a frequency-select code to the clock generator and a voltage-identifier code to an external regulator. The order of the two changes depends on the direction of the move, so that the supply is never below what the running frequency needs.

A move to a lower point changes the frequency code first and lowers the voltage code on the next cycle. A move to a higher point raises the voltage code first. It then waits until the regulator reports that the rail has settled, or until a programmable settle time has run out, whichever comes first. Only after that does it raise the frequency code. A target written while a move is in progress is held and started once the move has finished. A target equal to the current point changes nothing.

Top module: `vfs_sequencer`

## Requirements
- R1: After a synchronous reset, `freq_sel` and `vid_out` hold the codes of point 0, `cur_idx` is 0 and `busy` is 0.
- R2: The default table maps index 0..3 to frequency codes 3, 6, 9, 12 and voltage codes 20, 28, 36, 44. Once settled at point i, the outputs carry exactly entry i.
- R3: For a target index below `cur_idx`, `freq_sel` takes the target code on the accepting clock edge. `vid_out` takes the target code one edge later, and on that same edge `busy` falls and `cur_idx` is updated.
- R4: For a target index above `cur_idx`, `vid_out` takes the target code on the accepting edge. `freq_sel` keeps its old code until the settle condition is met, and takes the target code on that edge.
- R5: While waiting on a rise, a high `vr_settled` sampled on any edge after the accepting edge completes the move on that edge.
- R6: Without `vr_settled`, a rise completes on the edge that is `settle_limit` edges after the accepting edge. A `settle_limit` of 0 acts as 1.
- R7: A target written while `busy` is high is held, and the last such write wins. It is started on the edge after the current move completes. If a write and the held target meet in an idle cycle, the write wins.
- R8: Writing a target equal to `cur_idx` while idle leaves `freq_sel`, `vid_out` and `cur_idx` unchanged and keeps `busy` low.
- R9: `busy` is high from the accepting edge until both outputs match the target entry. Whenever `busy` is low, the outputs equal the entry at `cur_idx`.
- R10: A move across several points (for example 0 to 3) is one transition straight to the target entry, with no intermediate points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_we | input | 1 | Target write strobe |
| tgt_idx | input | 2 | Target point index |
| settle_limit | input | 16 | Settle timeout in cycles |
| vr_settled | input | 1 | Regulator reports rail settled |
| freq_sel | output | 4 | Frequency-select code |
| vid_out | output | 6 | Voltage-identifier code to the regulator |
| busy | output | 1 | Transition in progress |
| cur_idx | output | 2 | Index of the point currently applied |

## Verification
The case that needs care is a new target write arriving on the same edge that a rise completes because `vr_settled` went high. On that edge the held-target capture and the completion of the move coincide. The bench provokes it by raising `vr_settled` and `tgt_we` in the same cycle during a rise. A behavioural reference model, compared on every clock, then expects the move to finish and the captured target to start a fall on the following edge. A second case has several writes landing during a long timeout wait, and only the last of them may be started.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VDOWN = 2'd1,
    ST_VWAIT = 2'd2
  } vfs_state_e;
endpackage

// File: rtl/vfs_point_table.sv
module vfs_point_table #(
  parameter int NUM_PTS = 4,
  parameter int IDX_W   = 2,
  parameter int FREQ_W  = 4,
  parameter int VID_W   = 6,
  parameter logic [NUM_PTS*FREQ_W-1:0] FREQ_TABLE = '0,
  parameter logic [NUM_PTS*VID_W-1:0]  VID_TABLE  = '0
) (
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  output logic [FREQ_W-1:0] freq_a,
  output logic [VID_W-1:0]  vid_a,
  output logic [FREQ_W-1:0] freq_b,
  output logic [VID_W-1:0]  vid_b
);
  logic [FREQ_W-1:0] freq_mem [NUM_PTS];
  logic [VID_W-1:0]  vid_mem  [NUM_PTS];

  // Unpack the flat parameter vectors, entry 0 in the lowest bits
  for (genvar g = 0; g < NUM_PTS; g++) begin : g_unpack
    assign freq_mem[g] = FREQ_TABLE[g*FREQ_W +: FREQ_W];
    assign vid_mem[g]  = VID_TABLE[g*VID_W +: VID_W];
  end

  assign freq_a = freq_mem[idx_a];
  assign vid_a  = vid_mem[idx_a];
  assign freq_b = freq_mem[idx_b];
  assign vid_b  = vid_mem[idx_b];
endmodule

// File: rtl/vfs_settle_timer.sv
module vfs_settle_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  localparam int EXT_W = TMR_W + 1;

  logic [TMR_W-1:0] cnt;
  logic [EXT_W-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt} + EXT_W'(1);
  // A limit of 0 compares as reached at once, giving it the effect of 1
  assign expired  = en && (cnt_next >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt_next[TMR_W-1:0];
  end

  assert_timer_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/vfs_req_latch.sv
module vfs_req_latch #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             consume,
  output logic             pend_v,
  output logic [IDX_W-1:0] pend_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
    end else if (capture) begin
      pend_v   <= 1'b1;
      pend_idx <= cap_idx;
    end else if (consume) begin
      pend_v   <= 1'b0;
    end
  end

  assert_hold_last_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> (pend_v && pend_idx == $past(cap_idx)));
endmodule

// File: rtl/vfs_sequencer.sv
module vfs_sequencer #(
  parameter int NUM_PTS = 4,
  parameter int FREQ_W  = 4,
  parameter int VID_W   = 6,
  parameter int TMR_W   = 16,
  parameter logic [NUM_PTS*FREQ_W-1:0] FREQ_TABLE = {4'd12, 4'd9, 4'd6, 4'd3},
  parameter logic [NUM_PTS*VID_W-1:0]  VID_TABLE  = {6'd44, 6'd36, 6'd28, 6'd20},
  localparam int IDX_W = $clog2(NUM_PTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tgt_we,
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [TMR_W-1:0]  settle_limit,
  input  logic              vr_settled,
  output logic [FREQ_W-1:0] freq_sel,
  output logic [VID_W-1:0]  vid_out,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx
);
  import vfs_pkg::*;

  vfs_state_e        state;
  logic [IDX_W-1:0]  dest_idx;
  logic              pend_v;
  logic [IDX_W-1:0]  pend_idx;
  logic              req_hit;
  logic [IDX_W-1:0]  req_idx;
  logic              start;
  logic              going_up;
  logic [IDX_W-1:0]  look_idx;
  logic [FREQ_W-1:0] freq_tgt;
  logic [VID_W-1:0]  vid_tgt;
  logic [FREQ_W-1:0] freq_cur;
  logic [VID_W-1:0]  vid_cur;
  logic              tmr_expired;
  logic              settle_done;
  logic              in_idle;
  logic              in_wait;

  assign in_idle  = (state == ST_IDLE);
  assign in_wait  = (state == ST_VWAIT);
  // A fresh write takes precedence over a held one
  assign req_hit  = tgt_we | pend_v;
  assign req_idx  = tgt_we ? tgt_idx : pend_idx;
  assign start    = in_idle && req_hit && (req_idx != cur_idx);
  assign going_up = (req_idx > cur_idx);
  assign look_idx = in_idle ? req_idx : dest_idx;

  vfs_point_table #(
    .NUM_PTS(NUM_PTS), .IDX_W(IDX_W), .FREQ_W(FREQ_W), .VID_W(VID_W),
    .FREQ_TABLE(FREQ_TABLE), .VID_TABLE(VID_TABLE)
  ) u_table (
    .idx_a (look_idx),
    .idx_b (cur_idx),
    .freq_a(freq_tgt),
    .vid_a (vid_tgt),
    .freq_b(freq_cur),
    .vid_b (vid_cur)
  );

  vfs_settle_timer #(.TMR_W(TMR_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .en     (in_wait),
    .limit  (settle_limit),
    .expired(tmr_expired)
  );

  assign settle_done = in_wait && (vr_settled || tmr_expired);

  vfs_req_latch #(.IDX_W(IDX_W)) u_req (
    .clk     (clk),
    .rst     (rst),
    .capture (tgt_we && !in_idle),
    .cap_idx (tgt_idx),
    .consume (in_idle),
    .pend_v  (pend_v),
    .pend_idx(pend_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dest_idx <= '0;
      cur_idx  <= '0;
      busy     <= 1'b0;
      freq_sel <= FREQ_TABLE[FREQ_W-1:0];
      vid_out  <= VID_TABLE[VID_W-1:0];
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dest_idx <= req_idx;
            busy     <= 1'b1;
            if (going_up) begin
              vid_out <= vid_tgt;
              state   <= ST_VWAIT;
            end else begin
              freq_sel <= freq_tgt;
              state    <= ST_VDOWN;
            end
          end
        end
        ST_VDOWN: begin
          vid_out <= vid_tgt;
          cur_idx <= dest_idx;
          busy    <= 1'b0;
          state   <= ST_IDLE;
        end
        ST_VWAIT: begin
          if (settle_done) begin
            freq_sel <= freq_tgt;
            cur_idx  <= dest_idx;
            busy     <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_matches_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (freq_sel == freq_cur && vid_out == vid_cur));

  assert_rise_volt_first_R4: assert property (@(posedge clk) disable iff (rst)
    (freq_sel > $past(freq_sel)) |-> (vid_out == $past(vid_out)));

  assert_fall_freq_first_R3: assert property (@(posedge clk) disable iff (rst)
    (vid_out < $past(vid_out)) |-> (freq_sel == $past(freq_sel)));

  assert_same_target_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && tgt_we && tgt_idx == cur_idx) |=>
      (!busy && $stable(freq_sel) && $stable(vid_out) && $stable(cur_idx)));
endmodule

// File: tb/test_vfs_sequencer.sv
module test_vfs_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tgt_we = 1'b0;
  logic [1:0]  tgt_idx = '0;
  logic [15:0] settle_limit = 16'd4;
  logic        vr_settled = 1'b0;
  logic [3:0]  freq_sel;
  logic [5:0]  vid_out;
  logic        busy;
  logic [1:0]  cur_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int f_tab [4] = '{3, 6, 9, 12};
  int v_tab [4] = '{20, 28, 36, 44};

  // behavioural reference model state
  int m_ph, m_cur, m_dest, m_freq, m_vid, m_busy, m_t, m_pv, m_pi;

  vfs_sequencer i_vfs_sequencer (
    .clk(clk), .rst(rst), .tgt_we(tgt_we), .tgt_idx(tgt_idx),
    .settle_limit(settle_limit), .vr_settled(vr_settled),
    .freq_sel(freq_sel), .vid_out(vid_out), .busy(busy), .cur_idx(cur_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cur = 0; m_dest = 0; m_freq = f_tab[0]; m_vid = v_tab[0];
      m_busy = 0; m_t = 0; m_pv = 0; m_pi = 0;
    end else begin
      if (m_ph == 0) begin
        int r;
        bit have;
        have = tgt_we || (m_pv != 0);
        r = tgt_we ? int'(tgt_idx) : m_pi;
        m_pv = 0;
        if (have && r != m_cur) begin
          m_dest = r; m_busy = 1;
          if (r > m_cur) begin m_vid = v_tab[r]; m_t = 0; m_ph = 2; end
          else begin m_freq = f_tab[r]; m_ph = 1; end
        end
      end else begin
        if (tgt_we) begin m_pv = 1; m_pi = int'(tgt_idx); end
        if (m_ph == 1) begin
          m_vid = v_tab[m_dest]; m_cur = m_dest; m_busy = 0; m_ph = 0;
        end else if (vr_settled || (m_t + 1 >= int'(settle_limit))) begin
          m_freq = f_tab[m_dest]; m_cur = m_dest; m_busy = 0; m_ph = 0;
        end else begin
          m_t++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, int'(freq_sel), m_freq, "freq_sel");
      chk(tag, int'(vid_out), m_vid, "vid_out");
      chk(tag, int'(busy), m_busy, "busy");
      chk(tag, int'(cur_idx), m_cur, "cur_idx");
    end
  end

  task automatic go(input int idx, output int n);
    @(negedge clk);
    tgt_we = 1'b1; tgt_idx = 2'(idx);
    @(negedge clk);
    tgt_we = 1'b0;
    n = 0;
    while (busy && n < 70000) begin n++; @(negedge clk); end
  endtask

  task automatic settle_then(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    chk("R1", int'(freq_sel), 3, "reset freq_sel");
    chk("R1", int'(vid_out), 20, "reset vid_out");
    chk("R1", int'(cur_idx), 0, "reset cur_idx");
    chk("R1", int'(busy), 0, "reset busy");

    tag = "R8";
    go(0, n);
    chk("R8", n, 0, "busy cycles same target");
    chk("R8", int'(vid_out), 20, "vid after same target");

    tag = "R6";
    settle_limit = 16'd5;
    go(2, n);
    chk("R6", n, 5, "busy cycles timeout rise");
    chk("R4", int'(freq_sel), 9, "freq after rise");

    tag = "R3";
    go(1, n);
    chk("R3", n, 1, "busy cycles fall");
    chk("R3", int'(vid_out), 28, "vid after fall");

    tag = "R5";
    settle_limit = 16'd1000;
    @(negedge clk);
    tgt_we = 1'b1; tgt_idx = 2'd3;
    @(negedge clk);
    tgt_we = 1'b0;
    chk("R4", int'(freq_sel), 6, "freq held during rise");
    chk("R4", int'(vid_out), 44, "vid raised first");
    @(negedge clk);
    vr_settled = 1'b1;
    @(negedge clk);
    vr_settled = 1'b0;
    chk("R5", int'(busy), 0, "busy after settled");
    chk("R5", int'(freq_sel), 12, "freq after settled");

    tag = "R10";
    go(0, n);
    settle_limit = 16'd3;
    go(3, n);
    chk("R10", n, 3, "busy cycles skip rise");
    chk("R10", int'(vid_out), 44, "vid after skip");
    go(0, n);

    tag = "R7";
    settle_limit = 16'd6;
    @(negedge clk);
    tgt_we = 1'b1; tgt_idx = 2'd2;
    @(negedge clk);
    tgt_idx = 2'd3;
    @(negedge clk);
    tgt_idx = 2'd1;
    @(negedge clk);
    tgt_we = 1'b0;
    settle_then(10);
    chk("R7", int'(cur_idx), 1, "last held target applied");
    chk("R7", int'(freq_sel), 6, "freq after held target");

    // write lands on the edge the rise completes
    settle_limit = 16'd1000;
    @(negedge clk);
    tgt_we = 1'b1; tgt_idx = 2'd3;
    @(negedge clk);
    tgt_we = 1'b0;
    @(negedge clk);
    vr_settled = 1'b1; tgt_we = 1'b1; tgt_idx = 2'd0;
    @(negedge clk);
    vr_settled = 1'b0; tgt_we = 1'b0;
    chk("R7", int'(freq_sel), 12, "rise done at coincident write");
    settle_then(4);
    chk("R7", int'(cur_idx), 0, "coincident write started");

    tag = "R6";
    settle_limit = 16'd0;
    go(1, n);
    chk("R6", n, 1, "zero limit acts as one");

    tag = "R2";
    settle_limit = 16'd2;
    for (int i = 3; i >= 0; i--) begin
      go(i, n);
      chk("R2", int'(freq_sel), f_tab[i], "table freq");
      chk("R2", int'(vid_out), v_tab[i], "table vid");
      chk("R9", int'(busy), 0, "busy low when matched");
    end

    settle_then(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule